// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code and the operand bytes of an instruction into a 24-bit effective address. The upper eight bits are a bank number; the lower sixteen are an offset. It serves a 16-bit processor core whose program and data banks are held in separate 8-bit registers. The core supplies the current register state: the direct-page base, the stack pointer, the two index registers and the two bank registers. It also supplies the address of the next instruction and, for the indirect modes, the pointer value it has already read from memory.

The mode decides how the bank byte is formed:
- It is forced to zero.
- It is copied from the data bank register.
- It is copied from the program bank register.
- It is produced by a full 24-bit add, so that an index carry ripples into it.

Two flags tell the sequencer to insert one more cycle:
- One flag marks a direct-page base that is not page aligned.
- The other marks an indexed address whose page differs from the page of its unindexed base.

For the indirect modes, the block also returns the bank-zero location of the pointer, so that the sequencer can fetch it. All results are registered: they appear one clock after the inputs are presented.

Top module: `ea_gen`

## Requirements
- R1: Modes direct (code 0), direct+X (code 1) and direct+Y (code 2) give bank 0x00 with offset (D + zero-extended operand byte + index) modulo 2^16.
- R2: `dp_slow_o` is 1 exactly when the mode is a direct-page one (codes 0, 1, 2, 8, 9, 10, 11, 12) and bits 7:0 of the direct register are nonzero.
- R3: Modes absolute (code 3), absolute+X (code 4) and absolute+Y (code 5) give the data bank register as bits 23:16, with offset (operand bits 15:0 + index) modulo 2^16.
- R4: Absolute long (code 6) gives the 24-bit operand unchanged. Absolute long+X (code 7) gives (operand + X) modulo 2^24, so a carry reaches the bank byte.
- R5: Direct indirect (code 8) and direct-X indirect (code 9) give {data bank, pointer bits 15:0}. Direct indirect long (code 11) gives the 24-bit pointer.
- R6: Direct indirect +Y (code 10) and stack-relative indirect +Y (code 14) give ({data bank, pointer bits 15:0} + Y) modulo 2^24. Direct indirect long +Y (code 12) gives (pointer + Y) modulo 2^24.
- R7: `ptr_addr_o` is (D + operand byte) mod 2^16 for codes 8, 10, 11 and 12. It is (D + operand byte + X) mod 2^16 for code 9, (S + operand byte) mod 2^16 for code 14, and zero for every other code.
- R8: Stack relative (code 13) gives bank 0x00 with offset (S + zero-extended operand byte) modulo 2^16.
- R9: Relative (code 15) adds the sign-extended operand byte, and relative long (code 16) adds operand bits 15:0, to the next-instruction address. The sum is taken modulo 2^16, and the program bank register supplies bits 23:16.
- R10: When `idx8_i` is 1, bits 15:8 of both X and Y are treated as zero in every mode that uses them.
- R11: `page_cross_o` is 1 exactly when the mode is one of codes 4, 5, 7, 10, 12 or 14 and bits 23:8 of the result differ from bits 23:8 of the unindexed base.
- R12: Codes 17 to 31 give a zero address, a zero pointer address and both flags at 0.
- R13: All outputs are registered with one cycle of latency, and a synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Addressing-mode code |
| oper_i | input | 24 | Instruction operand bytes, low byte first in bits 7:0 |
| dir_i | input | 16 | Direct-page base register |
| sp_i | input | 16 | Stack pointer |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| pc_next_i | input | 16 | Address of the next instruction |
| idx8_i | input | 1 | Index registers in 8-bit width |
| ptr_i | input | 24 | Pointer value fetched for the indirect modes |
| ea_o | output | 24 | Effective address |
| ptr_addr_o | output | 16 | Bank-zero location of the pointer |
| dp_slow_o | output | 1 | Extra cycle for an unaligned direct page |
| page_cross_o | output | 1 | Extra cycle for an indexed page crossing |

## Verification
The bench builds the block with its default widths: a 16-bit word and an 8-bit bank byte. With these widths, short operand values reach the interesting boundaries:
- 16-bit wraparound in the direct, absolute and relative modes, where the bank byte must stay fixed.
- Carries out of the offset into the bank byte in the long and indirect-Y modes.
- Negative branch offsets that wrap below the start of the bank.
- Index values whose upper byte must disappear when the 8-bit index width is selected.

// File: rtl/ea_pkg.sv
// Package: shared mode encoding and mode-class helpers for the address generator.
// Assumes a 5-bit mode code; codes above AM_REL16 are undefined.
package ea_pkg;

    typedef enum logic [4:0] {
        AM_DIR        = 5'd0,
        AM_DIR_X      = 5'd1,
        AM_DIR_Y      = 5'd2,
        AM_ABS        = 5'd3,
        AM_ABS_X      = 5'd4,
        AM_ABS_Y      = 5'd5,
        AM_LONG       = 5'd6,
        AM_LONG_X     = 5'd7,
        AM_DP_IND     = 5'd8,
        AM_DP_X_IND   = 5'd9,
        AM_DP_IND_Y   = 5'd10,
        AM_DP_LIND    = 5'd11,
        AM_DP_LIND_Y  = 5'd12,
        AM_STK        = 5'd13,
        AM_STK_IND_Y  = 5'd14,
        AM_REL8       = 5'd15,
        AM_REL16      = 5'd16
    } am_e;

    // True for every mode whose address is built on the direct-page base
    function automatic logic uses_dp(input am_e m);
        return m inside {AM_DIR, AM_DIR_X, AM_DIR_Y, AM_DP_IND, AM_DP_X_IND,
                         AM_DP_IND_Y, AM_DP_LIND, AM_DP_LIND_Y};
    endfunction

endpackage

// File: rtl/ea_index_mask.sv
// Module: presents X and Y at their active width.
// Assumes that when narrow_i is set, the upper byte(s) of both index registers read as zero.
module ea_index_mask #(
    parameter int WORD_W = 16,
    parameter int LO_W   = 8
) (
    input  logic              narrow_i,
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    output logic [WORD_W-1:0] x_eff_o,
    output logic [WORD_W-1:0] y_eff_o
);
    localparam int HI_W = WORD_W - LO_W;

    logic [WORD_W-1:0] raw [2];
    logic [WORD_W-1:0] eff [2];

    assign raw[0] = x_i;
    assign raw[1] = y_i;

    // One masking slice per index register
    for (genvar gi = 0; gi < 2; gi++) begin : g_idx
        assign eff[gi] = narrow_i ? {{HI_W{1'b0}}, raw[gi][LO_W-1:0]} : raw[gi];
    end

    assign x_eff_o = eff[0];
    assign y_eff_o = eff[1];
endmodule

// File: rtl/ea_ptr_unit.sv
// Module: forms the bank-zero pointer location for indirect modes and the
// unaligned-direct-page flag. Purely combinational; assumes an 8-bit offset field.
module ea_ptr_unit
    import ea_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OFF_W  = 8
) (
    input  am_e               mode_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [WORD_W-1:0] dir_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] x_eff_i,
    output logic [WORD_W-1:0] ptr_addr_o,
    output logic              dp_slow_o
);
    localparam int PAD_W = WORD_W - OFF_W;

    logic [WORD_W-1:0] off_ext;
    logic [WORD_W-1:0] dp_base;

    assign off_ext = {{PAD_W{1'b0}}, off_i};
    assign dp_base = dir_i + off_ext;

    // Select the pointer location by mode
    always_comb begin
        unique case (mode_i)
            AM_DP_IND, AM_DP_IND_Y,
            AM_DP_LIND, AM_DP_LIND_Y: ptr_addr_o = dp_base;
            AM_DP_X_IND:              ptr_addr_o = dp_base + x_eff_i;
            AM_STK_IND_Y:             ptr_addr_o = sp_i + off_ext;
            default:                  ptr_addr_o = '0;
        endcase
    end

    // Extra cycle whenever a direct-page mode sees a base that is not page aligned
    assign dp_slow_o = uses_dp(mode_i) && (dir_i[OFF_W-1:0] != '0);
endmodule

// File: rtl/ea_calc.sv
// Module: main effective-address multiplexer and page-cross detector.
// Purely combinational; assumes the index inputs are already width-masked.
module ea_calc
    import ea_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8,
    parameter int OFF_W  = 8
) (
    input  am_e                      mode_i,
    input  logic [BANK_W+WORD_W-1:0] oper_i,
    input  logic [WORD_W-1:0]        dir_i,
    input  logic [WORD_W-1:0]        sp_i,
    input  logic [WORD_W-1:0]        x_eff_i,
    input  logic [WORD_W-1:0]        y_eff_i,
    input  logic [BANK_W-1:0]        dbank_i,
    input  logic [BANK_W-1:0]        pbank_i,
    input  logic [WORD_W-1:0]        pc_next_i,
    input  logic [BANK_W+WORD_W-1:0] ptr_i,
    output logic [BANK_W+WORD_W-1:0] ea_o,
    output logic                     page_cross_o
);
    localparam int ADDR_W = BANK_W + WORD_W;
    localparam int PAD_W  = WORD_W - OFF_W;

    logic [WORD_W-1:0] off_zx;
    logic [WORD_W-1:0] off_sx;
    logic [WORD_W-1:0] op16;
    logic [WORD_W-1:0] dp_sum;
    logic [ADDR_W-1:0] x_wide;
    logic [ADDR_W-1:0] y_wide;
    logic [ADDR_W-1:0] ind_base;
    logic [ADDR_W-1:0] base;
    logic              indexed;

    assign off_zx   = {{PAD_W{1'b0}}, oper_i[OFF_W-1:0]};
    assign off_sx   = {{PAD_W{oper_i[OFF_W-1]}}, oper_i[OFF_W-1:0]};
    assign op16     = oper_i[WORD_W-1:0];
    assign dp_sum   = dir_i + off_zx;
    assign x_wide   = {{BANK_W{1'b0}}, x_eff_i};
    assign y_wide   = {{BANK_W{1'b0}}, y_eff_i};
    assign ind_base = {dbank_i, ptr_i[WORD_W-1:0]};

    // Form the address and remember the unindexed base for page-cross detection
    always_comb begin
        base    = '0;
        indexed = 1'b0;
        ea_o    = '0;
        unique case (mode_i)
            AM_DIR:       ea_o = {{BANK_W{1'b0}}, dp_sum};
            AM_DIR_X:     ea_o = {{BANK_W{1'b0}}, dp_sum + x_eff_i};
            AM_DIR_Y:     ea_o = {{BANK_W{1'b0}}, dp_sum + y_eff_i};
            AM_ABS:       ea_o = {dbank_i, op16};
            AM_ABS_X: begin
                base = {dbank_i, op16}; indexed = 1'b1;
                ea_o = {dbank_i, op16 + x_eff_i};
            end
            AM_ABS_Y: begin
                base = {dbank_i, op16}; indexed = 1'b1;
                ea_o = {dbank_i, op16 + y_eff_i};
            end
            AM_LONG:      ea_o = oper_i;
            AM_LONG_X: begin
                base = oper_i; indexed = 1'b1;
                ea_o = oper_i + x_wide;
            end
            AM_DP_IND, AM_DP_X_IND: ea_o = ind_base;
            AM_DP_IND_Y, AM_STK_IND_Y: begin
                base = ind_base; indexed = 1'b1;
                ea_o = ind_base + y_wide;
            end
            AM_DP_LIND:   ea_o = ptr_i;
            AM_DP_LIND_Y: begin
                base = ptr_i; indexed = 1'b1;
                ea_o = ptr_i + y_wide;
            end
            AM_STK:       ea_o = {{BANK_W{1'b0}}, sp_i + off_zx};
            AM_REL8:      ea_o = {pbank_i, pc_next_i + off_sx};
            AM_REL16:     ea_o = {pbank_i, pc_next_i + op16};
            default:      ea_o = '0;
        endcase
    end

    // Page crossing: page number of result differs from that of the base
    assign page_cross_o = indexed && (base[ADDR_W-1:OFF_W] != ea_o[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/ea_gen.sv
// Module: top of the banked effective-address generator. Combines index masking,
// pointer-location logic and the address multiplexer, then registers every result.
// Assumes synchronous active-low reset; one cycle from inputs to outputs.
module ea_gen
    import ea_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4:0]               mode_i,
    input  logic [BANK_W+WORD_W-1:0] oper_i,
    input  logic [WORD_W-1:0]        dir_i,
    input  logic [WORD_W-1:0]        sp_i,
    input  logic [WORD_W-1:0]        x_i,
    input  logic [WORD_W-1:0]        y_i,
    input  logic [BANK_W-1:0]        dbank_i,
    input  logic [BANK_W-1:0]        pbank_i,
    input  logic [WORD_W-1:0]        pc_next_i,
    input  logic                     idx8_i,
    input  logic [BANK_W+WORD_W-1:0] ptr_i,
    output logic [BANK_W+WORD_W-1:0] ea_o,
    output logic [WORD_W-1:0]        ptr_addr_o,
    output logic                     dp_slow_o,
    output logic                     page_cross_o
);
    localparam int ADDR_W = BANK_W + WORD_W;
    localparam int OFF_W  = WORD_W / 2;

    am_e               mode;
    logic [WORD_W-1:0] x_eff;
    logic [WORD_W-1:0] y_eff;
    logic [ADDR_W-1:0] ea_d;
    logic [WORD_W-1:0] ptr_d;
    logic              dp_slow_d;
    logic              cross_d;

    assign mode = am_e'(mode_i);

    ea_index_mask #(.WORD_W(WORD_W), .LO_W(OFF_W)) u_mask (
        .narrow_i (idx8_i),
        .x_i      (x_i),
        .y_i      (y_i),
        .x_eff_o  (x_eff),
        .y_eff_o  (y_eff)
    );

    ea_ptr_unit #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_ptr (
        .mode_i     (mode),
        .off_i      (oper_i[OFF_W-1:0]),
        .dir_i      (dir_i),
        .sp_i       (sp_i),
        .x_eff_i    (x_eff),
        .ptr_addr_o (ptr_d),
        .dp_slow_o  (dp_slow_d)
    );

    ea_calc #(.WORD_W(WORD_W), .BANK_W(BANK_W), .OFF_W(OFF_W)) u_calc (
        .mode_i       (mode),
        .oper_i       (oper_i),
        .dir_i        (dir_i),
        .sp_i         (sp_i),
        .x_eff_i      (x_eff),
        .y_eff_i      (y_eff),
        .dbank_i      (dbank_i),
        .pbank_i      (pbank_i),
        .pc_next_i    (pc_next_i),
        .ptr_i        (ptr_i),
        .ea_o         (ea_d),
        .page_cross_o (cross_d)
    );

    // Output register stage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o         <= '0;
            ptr_addr_o   <= '0;
            dp_slow_o    <= 1'b0;
            page_cross_o <= 1'b0;
        end else begin
            ea_o         <= ea_d;
            ptr_addr_o   <= ptr_d;
            dp_slow_o    <= dp_slow_d;
            page_cross_o <= cross_d;
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
// Module: protocol checker for ea_gen, attached by bind. Relates registered outputs
// to the inputs of the previous cycle; only active once a full cycle out of reset.
module ea_gen_chk
    import ea_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [4:0]               mode_i,
    input logic [7:0]               dir_lo_i,
    input logic [BANK_W-1:0]        dbank_i,
    input logic [BANK_W-1:0]        pbank_i,
    input logic [BANK_W+WORD_W-1:0] ea_o,
    input logic [WORD_W-1:0]        ptr_addr_o,
    input logic                     dp_slow_o,
    input logic                     page_cross_o
);
    localparam int ADDR_W = BANK_W + WORD_W;

    logic primed  = 1'b0;
    logic was_rst = 1'b0;

    // Marks that the previous edge was taken out of reset
    always_ff @(posedge clk) begin
        primed  <= rst_n;
        was_rst <= !rst_n;
    end

    // R13
    always @(posedge clk) begin
        if (was_rst) begin
            reset_clear_chk: assert (ea_o == '0 && ptr_addr_o == '0 && !dp_slow_o && !page_cross_o);
        end
    end

    // R1
    dir_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(mode_i) <= 5'd2 |-> ea_o[ADDR_W-1:WORD_W] == '0);

    // R2
    dp_aligned_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(dir_lo_i) == 8'h00 |-> !dp_slow_o);

    // R3
    abs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(mode_i) >= 5'd3 && $past(mode_i) <= 5'd5)
        |-> ea_o[ADDR_W-1:WORD_W] == $past(dbank_i));

    // R8
    stk_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(mode_i) == 5'd13 |-> ea_o[ADDR_W-1:WORD_W] == '0);

    // R9
    rel_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(mode_i) == 5'd15 || $past(mode_i) == 5'd16)
        |-> ea_o[ADDR_W-1:WORD_W] == $past(pbank_i));

    // R11
    unindexed_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(mode_i) == 5'd3 || $past(mode_i) == 5'd6 || $past(mode_i) == 5'd13)
        |-> !page_cross_o);

    // R12
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(mode_i) > 5'd16
        |-> ea_o == '0 && ptr_addr_o == '0 && !dp_slow_o && !page_cross_o);
endmodule

bind ea_gen ea_gen_chk #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .dir_lo_i     (dir_i[7:0]),
    .dbank_i      (dbank_i),
    .pbank_i      (pbank_i),
    .ea_o         (ea_o),
    .ptr_addr_o   (ptr_addr_o),
    .dp_slow_o    (dp_slow_o),
    .page_cross_o (page_cross_o)
);

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver pushes expected results computed from the
// requirements; the monitor pops one per clock and compares with the outputs.
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = '0;
    logic [23:0] oper_i = '0;
    logic [15:0] dir_i = '0, sp_i = '0, x_i = '0, y_i = '0, pc_next_i = '0;
    logic [7:0]  dbank_i = '0, pbank_i = '0;
    logic        idx8_i = 1'b0;
    logic [23:0] ptr_i = '0;
    logic [23:0] ea_o;
    logic [15:0] ptr_addr_o;
    logic        dp_slow_o, page_cross_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [23:0] ea;
        logic [15:0] pa;
        logic        ds;
        logic        pc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .oper_i(oper_i), .dir_i(dir_i),
        .sp_i(sp_i), .x_i(x_i), .y_i(y_i), .dbank_i(dbank_i), .pbank_i(pbank_i),
        .pc_next_i(pc_next_i), .idx8_i(idx8_i), .ptr_i(ptr_i), .ea_o(ea_o),
        .ptr_addr_o(ptr_addr_o), .dp_slow_o(dp_slow_o), .page_cross_o(page_cross_o)
    );

    // Reference model written from the requirement list
    function automatic exp_t predict(string tag);
        exp_t e;
        int xv, yv, b8, w16, s8, base, res;
        bit idx;
        xv  = idx8_i ? int'(x_i[7:0]) : int'(x_i);               // R10
        yv  = idx8_i ? int'(y_i[7:0]) : int'(y_i);
        b8  = int'(oper_i[7:0]);
        w16 = int'(oper_i[15:0]);
        s8  = b8 >= 128 ? b8 - 256 : b8;
        base = 0; res = 0; idx = 1'b0;
        e.pa = '0;
        case (mode_i)
            0:  res = (int'(dir_i) + b8) & 'hFFFF;
            1:  res = (int'(dir_i) + b8 + xv) & 'hFFFF;
            2:  res = (int'(dir_i) + b8 + yv) & 'hFFFF;
            3:  res = int'(dbank_i) * 65536 + w16;
            4:  begin base = int'(dbank_i) * 65536 + w16; idx = 1;
                      res = int'(dbank_i) * 65536 + ((w16 + xv) & 'hFFFF); end
            5:  begin base = int'(dbank_i) * 65536 + w16; idx = 1;
                      res = int'(dbank_i) * 65536 + ((w16 + yv) & 'hFFFF); end
            6:  res = int'(oper_i);
            7:  begin base = int'(oper_i); idx = 1; res = (base + xv) & 'hFFFFFF; end
            8, 9: res = int'(dbank_i) * 65536 + int'(ptr_i[15:0]);
            10, 14: begin base = int'(dbank_i) * 65536 + int'(ptr_i[15:0]); idx = 1;
                      res = (base + yv) & 'hFFFFFF; end
            11: res = int'(ptr_i);
            12: begin base = int'(ptr_i); idx = 1; res = (base + yv) & 'hFFFFFF; end
            13: res = (int'(sp_i) + b8) & 'hFFFF;
            15: res = int'(pbank_i) * 65536 + ((int'(pc_next_i) + s8) & 'hFFFF);
            16: res = int'(pbank_i) * 65536 + ((int'(pc_next_i) + w16) & 'hFFFF);
            default: res = 0;
        endcase
        case (mode_i)
            8, 10, 11, 12: e.pa = 16'((int'(dir_i) + b8) & 'hFFFF);
            9:             e.pa = 16'((int'(dir_i) + b8 + xv) & 'hFFFF);
            14:            e.pa = 16'((int'(sp_i) + b8) & 'hFFFF);
            default:       e.pa = '0;
        endcase
        e.ea  = 24'(res);
        e.ds  = (mode_i inside {5'd0, 5'd1, 5'd2, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12})
                && dir_i[7:0] != 8'h00;
        e.pc  = idx && ((base >> 8) != (res >> 8));
        e.tag = tag;
        return e;
    endfunction

    // Driver: inputs are already set at a falling edge; queue the prediction
    task automatic send(string tag);
        sb.push_back(predict(tag));
        @(negedge clk);
    endtask

    task automatic fail_line(string tag, string what, int act, int expv);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    endtask

    // Monitor: one cycle after each push, compare registered outputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (ea_o !== e.ea) fail_line(e.tag, "ea", int'(ea_o), int'(e.ea));
                else if (ptr_addr_o !== e.pa) fail_line(e.tag, "ptr_addr", int'(ptr_addr_o), int'(e.pa));
                else if (dp_slow_o !== e.ds) fail_line(e.tag, "dp_slow", int'(dp_slow_o), int'(e.ds));
                else if (page_cross_o !== e.pc) fail_line(e.tag, "page_cross", int'(page_cross_o), int'(e.pc));
            end
        end
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R13: outputs cleared during reset, even with live inputs
        mode_i = 5'd6; oper_i = 24'hABCDEF;
        repeat (3) @(negedge clk);
        checks++;
        if (ea_o !== '0 || ptr_addr_o !== '0 || dp_slow_o || page_cross_o)
            fail_line("R13", "reset", int'(ea_o), 0);
        rst_n = 1'b1;

        // R1 / R2: aligned direct page
        dbank_i = 8'h7E; pbank_i = 8'h03;
        mode_i = 5'd0; dir_i = 16'h1200; oper_i = 24'h000034; send("R1");
        // R2: unaligned direct page raises the flag
        dir_i = 16'h1201; send("R2");
        // R1: direct+X wraps within bank zero
        mode_i = 5'd1; dir_i = 16'hFF00; oper_i = 24'h0000F0; x_i = 16'h0020; send("R1");
        // R10: direct+Y with narrow index ignores Y high byte
        mode_i = 5'd2; dir_i = 16'h0000; oper_i = 24'h000010; y_i = 16'hAB05; idx8_i = 1'b1; send("R10");
        idx8_i = 1'b0;
        // R3: absolute uses the data bank
        mode_i = 5'd3; oper_i = 24'h008000; send("R3");
        // R11: absolute+X crossing a page
        mode_i = 5'd4; oper_i = 24'h0010F0; x_i = 16'h0020; send("R11");
        // R3: absolute+X wraps within the data bank
        oper_i = 24'h00FFF0; send("R3");
        // R10: absolute+Y narrow
        mode_i = 5'd5; oper_i = 24'h002000; y_i = 16'h1234; idx8_i = 1'b1; send("R10");
        idx8_i = 1'b0;
        // R4: absolute long
        mode_i = 5'd6; oper_i = 24'h12ABCD; send("R4");
        // R4: absolute long+X carries into bank
        mode_i = 5'd7; oper_i = 24'h12FFF0; x_i = 16'h0020; send("R4");
        // R5 / R7: direct indirect
        mode_i = 5'd8; dir_i = 16'h0300; oper_i = 24'h000044; ptr_i = 24'h55C0DE; send("R5");
        // R7: direct-X indirect pointer location
        mode_i = 5'd9; dir_i = 16'h0100; oper_i = 24'h000010; x_i = 16'h0005; send("R7");
        // R6: direct indirect +Y carries into bank
        mode_i = 5'd10; dir_i = 16'h0000; ptr_i = 24'h00FFF0; y_i = 16'h0020; send("R6");
        // R5: direct indirect long
        mode_i = 5'd11; ptr_i = 24'h3F1234; send("R5");
        // R6: direct indirect long +Y
        mode_i = 5'd12; ptr_i = 24'h01FFFF; y_i = 16'h0001; send("R6");
        // R8: stack relative
        mode_i = 5'd13; sp_i = 16'h01F0; oper_i = 24'h000020; send("R8");
        // R6 / R7: stack-relative indirect +Y
        mode_i = 5'd14; oper_i = 24'h000003; ptr_i = 24'h000100; y_i = 16'h0010; send("R6");
        // R9: negative short branch wraps within program bank
        mode_i = 5'd15; pc_next_i = 16'h0005; oper_i = 24'h0000F0; send("R9");
        // R9: long branch wraps within program bank
        mode_i = 5'd16; pc_next_i = 16'hFFF0; oper_i = 24'h000020; send("R9");
        // R12: undefined codes give zeros even with unaligned D
        mode_i = 5'd17; dir_i = 16'h00FF; send("R12");
        mode_i = 5'd31; send("R12");
        // R2: non-direct mode with unaligned D keeps flag low
        mode_i = 5'd3; send("R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule